// File: doc/BRIEF.md
# Effective Address Generation Unit

This block turns an operand specifier into either an effective address or an immediate operand value for a small register-based processor. Each request carries a 4-bit mode code, one or two register indices, a 16-bit displacement or immediate field, the program counter already advanced past the current instruction, a flag that marks the operand as a destination, and a flag that selects byte or word operand size. The block drives the two read indices of an external general-purpose register file and uses the data that comes back in the same cycle.

One cycle after a request, the block presents a registered result. The result holds the effective address, the immediate value, or the selected register number. Flags mark register operands, immediate operands and illegal specifiers. For the post-increment and pre-decrement modes, the same result also carries a write-back request that updates the pointer register. Memory is never accessed. For memory-indirect mode, the block therefore returns the address of the pointer word, and the caller fetches the pointer itself.

Top module: `ea_gen_unit`

## Requirements
- R1: `valid_o` is high in exactly the cycles that follow a cycle with `valid_i` high. All results are registered with one cycle of latency. After reset, `valid_o`, `wb_en_o`, `err_o`, `is_imm_o` and `is_reg_o` are low.
- R2: Mode 0 (register) sets `is_reg_o`. `ea_o` carries the zero-extended index `ri_idx_i`, and no write-back is requested.
- R3: Mode 1 (absolute) and mode 4 (memory-indirect) return the sign-extended displacement as `ea_o`. Neither mode flags a register, flags an immediate or requests a write-back.
- R4: Mode 2 (immediate) used as a source sets `is_imm_o`, and `ea_o` carries the sign-extended field.
- R5: Mode 2 with `is_dst_i` high, or any mode code from 11 to 15, sets `err_o`. In that case `ea_o` is 0, `is_imm_o`, `is_reg_o` and `wb_en_o` are low, and register contents are left unchanged.
- R6: Mode 3 (register indirect) returns the content of register `ri_idx_i`.
- R7: Mode 5 returns disp + [Ri]. Mode 6 returns [Ri] + [Rj]. Mode 7 returns disp + [Ri] + [Rj]. Ri is read through port A and Rj through port B.
- R8: Mode 8 (PC-relative) returns disp + `pc_i`.
- R9: Mode 9 (post-increment) returns [Ri] as `ea_o` and requests a write-back of [Ri] + size to Ri. The size is 1 when `size_word_i` is 0 and 4 when it is 1.
- R10: Mode 10 (pre-decrement) returns [Ri] − size. It requests a write-back of that same value to Ri.
- R11: The 16-bit displacement is sign-extended to 32 bits before any addition. Negative displacements therefore move the address downward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| mode_i | input | 4 | Addressing mode code |
| is_dst_i | input | 1 | Operand is a destination |
| size_word_i | input | 1 | 1 = word operand, 0 = byte operand |
| ri_idx_i | input | 4 | Primary register index |
| rj_idx_i | input | 4 | Secondary register index |
| disp_i | input | 16 | Displacement or immediate field |
| pc_i | input | 32 | Advanced program counter |
| rf_a_idx_o | output | 4 | Register file read index A |
| rf_b_idx_o | output | 4 | Register file read index B |
| rf_a_data_i | input | 32 | Register file read data A |
| rf_b_data_i | input | 32 | Register file read data B |
| valid_o | output | 1 | Result strobe |
| ea_o | output | 32 | Effective address, immediate value or register number |
| is_imm_o | output | 1 | Result is an immediate operand |
| is_reg_o | output | 1 | Result names a register operand |
| err_o | output | 1 | Illegal specifier |
| wb_en_o | output | 1 | Pointer register write-back request |
| wb_idx_o | output | 4 | Write-back register index |
| wb_data_o | output | 32 | Write-back value |

## Verification
The bench sends the same register values through every mode, which separates the address sources: a displacement alone, one register, two registers, and the program counter. Some displacements have bit 15 set. These distinguish sign extension from zero extension in the absolute, index and relative paths. Back-to-back post-increments first with a word size and then with a byte size show whether the write-back really reaches the register and whether the step follows the operand size. A pre-decrement on a different register shows whether the address is taken before or after the step. An immediate destination and a reserved code both check that errors block the write-back.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

  typedef enum logic [3:0] {
    AM_REG  = 4'd0,
    AM_ABS  = 4'd1,
    AM_IMM  = 4'd2,
    AM_RIND = 4'd3,
    AM_MIND = 4'd4,
    AM_IDX  = 4'd5,
    AM_RR   = 4'd6,
    AM_RRX  = 4'd7,
    AM_REL  = 4'd8,
    AM_AINC = 4'd9,
    AM_ADEC = 4'd10
  } amode_e;

  typedef enum logic [1:0] {
    SA_ZERO = 2'd0,
    SA_REG  = 2'd1,
    SA_PC   = 2'd2
  } sel_a_e;

  typedef enum logic [1:0] {
    SC_ZERO    = 2'd0,
    SC_DISP    = 2'd1,
    SC_NEGSTEP = 2'd2
  } sel_c_e;

  typedef struct packed {
    sel_a_e sel_a;
    logic   use_b;
    sel_c_e sel_c;
    logic   post_inc;
    logic   wb;
    logic   imm;
    logic   reg_op;
    logic   err;
  } ea_ctl_t;

endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import ea_gen_pkg::*;
(
  input  logic [3:0] mode_i,
  input  logic       is_dst_i,
  output ea_ctl_t    ctl_o
);

  always_comb begin
    ctl_o = '{sel_a: SA_ZERO, use_b: 1'b0, sel_c: SC_ZERO, post_inc: 1'b0,
              wb: 1'b0, imm: 1'b0, reg_op: 1'b0, err: 1'b0};
    case (mode_i)
      AM_REG:  ctl_o.reg_op = 1'b1;
      AM_ABS,
      AM_MIND: ctl_o.sel_c = SC_DISP;
      AM_IMM: begin
        if (is_dst_i) ctl_o.err = 1'b1;
        else begin
          ctl_o.sel_c = SC_DISP;
          ctl_o.imm   = 1'b1;
        end
      end
      AM_RIND: ctl_o.sel_a = SA_REG;
      AM_IDX: begin
        ctl_o.sel_a = SA_REG;
        ctl_o.sel_c = SC_DISP;
      end
      AM_RR: begin
        ctl_o.sel_a = SA_REG;
        ctl_o.use_b = 1'b1;
      end
      AM_RRX: begin
        ctl_o.sel_a = SA_REG;
        ctl_o.use_b = 1'b1;
        ctl_o.sel_c = SC_DISP;
      end
      AM_REL: begin
        ctl_o.sel_a = SA_PC;
        ctl_o.sel_c = SC_DISP;
      end
      AM_AINC: begin
        ctl_o.sel_a    = SA_REG;
        ctl_o.post_inc = 1'b1;
        ctl_o.wb       = 1'b1;
      end
      AM_ADEC: begin
        ctl_o.sel_a = SA_REG;
        ctl_o.sel_c = SC_NEGSTEP;
        ctl_o.wb    = 1'b1;
      end
      default: ctl_o.err = 1'b1;
    endcase
  end

endmodule

// File: rtl/ea_step.sv
module ea_step #(
  parameter int DW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic          size_word_i,
  output logic [DW-1:0] step_o,
  output logic [DW-1:0] neg_step_o
);

  localparam logic [DW-1:0] WordStep = DW'(WORD_BYTES);
  localparam logic [DW-1:0] ByteStep = DW'(1);

  assign step_o     = size_word_i ? WordStep : ByteStep;
  assign neg_step_o = '0 - step_o;

endmodule

// File: rtl/ea_add3.sv
module ea_add3 #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] c_i,
  output logic [DW-1:0] sum_o
);

  // carry-save stage keeps one carry chain for three operands
  logic [DW-1:0] s_w;
  logic [DW-1:0] c_w;

  for (genvar g = 0; g < DW; g++) begin : g_csa
    assign s_w[g] = a_i[g] ^ b_i[g] ^ c_i[g];
    if (g < DW - 1) begin : g_cy
      assign c_w[g+1] = (a_i[g] & b_i[g]) | (a_i[g] & c_i[g]) | (b_i[g] & c_i[g]);
    end
  end
  assign c_w[0] = 1'b0;

  assign sum_o = s_w + c_w;

endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
  import ea_gen_pkg::*;
#(
  parameter int DW         = 32,
  parameter int NREGS      = 16,
  parameter int DISPW      = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDXW      = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       mode_i,
  input  logic             is_dst_i,
  input  logic             size_word_i,
  input  logic [IDXW-1:0]  ri_idx_i,
  input  logic [IDXW-1:0]  rj_idx_i,
  input  logic [DISPW-1:0] disp_i,
  input  logic [DW-1:0]    pc_i,
  output logic [IDXW-1:0]  rf_a_idx_o,
  output logic [IDXW-1:0]  rf_b_idx_o,
  input  logic [DW-1:0]    rf_a_data_i,
  input  logic [DW-1:0]    rf_b_data_i,
  output logic             valid_o,
  output logic [DW-1:0]    ea_o,
  output logic             is_imm_o,
  output logic             is_reg_o,
  output logic             err_o,
  output logic             wb_en_o,
  output logic [IDXW-1:0]  wb_idx_o,
  output logic [DW-1:0]    wb_data_o
);

  ea_ctl_t       ctl;
  logic [DW-1:0] step, neg_step, disp_sx;
  logic [DW-1:0] a_val, b_val, c_val, sum;
  logic [DW-1:0] ea_d, wb_data_d;

  assign rf_a_idx_o = ri_idx_i;
  assign rf_b_idx_o = rj_idx_i;

  ea_mode_decode u_dec (
    .mode_i   (mode_i),
    .is_dst_i (is_dst_i),
    .ctl_o    (ctl)
  );

  ea_step #(.DW(DW), .WORD_BYTES(WORD_BYTES)) u_step (
    .size_word_i (size_word_i),
    .step_o      (step),
    .neg_step_o  (neg_step)
  );

  assign disp_sx = {{(DW-DISPW){disp_i[DISPW-1]}}, disp_i};

  always_comb begin
    case (ctl.sel_a)
      SA_REG:  a_val = rf_a_data_i;
      SA_PC:   a_val = pc_i;
      default: a_val = '0;
    endcase
    b_val = ctl.use_b ? rf_b_data_i : '0;
    case (ctl.sel_c)
      SC_DISP:    c_val = disp_sx;
      SC_NEGSTEP: c_val = neg_step;
      default:    c_val = '0;
    endcase
  end

  ea_add3 #(.DW(DW)) u_add (
    .a_i   (a_val),
    .b_i   (b_val),
    .c_i   (c_val),
    .sum_o (sum)
  );

  always_comb begin
    if (ctl.err)         ea_d = '0;
    else if (ctl.reg_op) ea_d = {{(DW-IDXW){1'b0}}, ri_idx_i};
    else                 ea_d = sum;
    wb_data_d = ctl.post_inc ? (rf_a_data_i + step) : sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      is_imm_o <= 1'b0;
      is_reg_o <= 1'b0;
      err_o    <= 1'b0;
      wb_en_o  <= 1'b0;
    end else begin
      valid_o  <= valid_i;
      is_imm_o <= valid_i & ctl.imm;
      is_reg_o <= valid_i & ctl.reg_op;
      err_o    <= valid_i & ctl.err;
      wb_en_o  <= valid_i & ctl.wb & ~ctl.err;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_o      <= '0;
      wb_idx_o  <= '0;
      wb_data_o <= '0;
    end else if (valid_i) begin
      ea_o      <= ea_d;
      wb_idx_o  <= ri_idx_i;
      wb_data_o <= wb_data_d;
    end
  end

endmodule

// File: rtl/ea_gen_unit_chk.sv
module ea_gen_unit_chk #(
  parameter int DW         = 32,
  parameter int IDXW       = 4,
  parameter int WORD_BYTES = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [3:0]      mode_i,
  input logic            is_dst_i,
  input logic            size_word_i,
  input logic [IDXW-1:0] ri_idx_i,
  input logic            valid_o,
  input logic [DW-1:0]   ea_o,
  input logic            is_imm_o,
  input logic            is_reg_o,
  input logic            err_o,
  input logic            wb_en_o,
  input logic [IDXW-1:0] wb_idx_o,
  input logic [DW-1:0]   wb_data_o
);

  a_r1_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r1_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  a_r5_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!wb_en_o && !is_imm_o && !is_reg_o && ea_o == '0));

  a_r5_imm_dst_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 4'd2 && is_dst_i) |=> err_o);

  a_r2_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({is_imm_o, is_reg_o, err_o, wb_en_o}));

  a_r9_inc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 4'd9) |=>
      (wb_en_o && (wb_data_o - ea_o) == ($past(size_word_i) ? DW'(WORD_BYTES) : DW'(1))));

  a_r10_dec_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 4'd10) |=> (wb_en_o && wb_data_o == ea_o));

  a_r10_wb_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (valid_o && wb_idx_o == $past(ri_idx_i)));

endmodule

bind ea_gen_unit ea_gen_unit_chk #(.DW(DW), .IDXW(IDXW), .WORD_BYTES(WORD_BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .mode_i      (mode_i),
  .is_dst_i    (is_dst_i),
  .size_word_i (size_word_i),
  .ri_idx_i    (ri_idx_i),
  .valid_o     (valid_o),
  .ea_o        (ea_o),
  .is_imm_o    (is_imm_o),
  .is_reg_o    (is_reg_o),
  .err_o       (err_o),
  .wb_en_o     (wb_en_o),
  .wb_idx_o    (wb_idx_o),
  .wb_data_o   (wb_data_o)
);

// File: tb/ea_gen_unit_bench.sv
`timescale 1ns/1ps
module ea_gen_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic        is_dst_i = 1'b0;
  logic        size_word_i = 1'b0;
  logic [3:0]  ri_idx_i = '0;
  logic [3:0]  rj_idx_i = '0;
  logic [15:0] disp_i = '0;
  logic [31:0] pc_i = '0;
  logic [3:0]  rf_a_idx, rf_b_idx;
  logic [31:0] rf_a_data, rf_b_data;
  logic        valid_o, is_imm_o, is_reg_o, err_o, wb_en_o;
  logic [31:0] ea_o, wb_data_o;
  logic [3:0]  wb_idx_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] rf [16];

  always #2.5 clk = ~clk;

  // register file model: reset preload, write-back from the block
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) rf[k] <= 32'd1000 + 32'(4 * k);
    end else if (wb_en_o) begin
      rf[wb_idx_o] <= wb_data_o;
    end
  end

  assign rf_a_data = rf[rf_a_idx];
  assign rf_b_data = rf[rf_b_idx];

  ea_gen_unit u_ea_gen_unit (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .valid_i     (valid_i),
    .mode_i      (mode_i),
    .is_dst_i    (is_dst_i),
    .size_word_i (size_word_i),
    .ri_idx_i    (ri_idx_i),
    .rj_idx_i    (rj_idx_i),
    .disp_i      (disp_i),
    .pc_i        (pc_i),
    .rf_a_idx_o  (rf_a_idx),
    .rf_b_idx_o  (rf_b_idx),
    .rf_a_data_i (rf_a_data),
    .rf_b_data_i (rf_b_data),
    .valid_o     (valid_o),
    .ea_o        (ea_o),
    .is_imm_o    (is_imm_o),
    .is_reg_o    (is_reg_o),
    .err_o       (err_o),
    .wb_en_o     (wb_en_o),
    .wb_idx_o    (wb_idx_o),
    .wb_data_o   (wb_data_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one request, sample 1 ns after the capturing edge
  task automatic issue(input logic [3:0] m, input logic dst, input logic wrd,
                       input logic [3:0] ri, input logic [3:0] rj,
                       input logic [15:0] d, input logic [31:0] pc);
    @(negedge clk);
    valid_i = 1'b1; mode_i = m; is_dst_i = dst; size_word_i = wrd;
    ri_idx_i = ri; rj_idx_i = rj; disp_i = d; pc_i = pc;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset valid_o", 32'(valid_o), 0);
    chk("R1 reset wb_en_o", 32'(wb_en_o), 0);
    chk("R1 reset flags", 32'({err_o, is_imm_o, is_reg_o}), 0);
  endtask

  task automatic t_register();
    issue(4'd0, 1'b0, 1'b1, 4'd7, 4'd0, 16'h1234, 32'h0);
    chk("R1 valid after request", 32'(valid_o), 1);
    chk("R2 is_reg_o", 32'(is_reg_o), 1);
    chk("R2 ea is index", ea_o, 32'd7);
    chk("R2 no wb", 32'(wb_en_o), 0);
    idle();
    chk("R1 valid drops", 32'(valid_o), 0);
  endtask

  task automatic t_absolute();
    issue(4'd1, 1'b0, 1'b1, 4'd3, 4'd0, 16'h0400, 32'h0);
    chk("R3 absolute ea", ea_o, 32'h0000_0400);
    chk("R3 absolute flags", 32'({is_imm_o, is_reg_o, wb_en_o, err_o}), 0);
    idle();
    issue(4'd4, 1'b1, 1'b1, 4'd3, 4'd0, 16'h0208, 32'h0);
    chk("R3 mem-indirect pointer addr", ea_o, 32'h0000_0208);
    chk("R3 mem-indirect no wb", 32'(wb_en_o), 0);
    idle();
  endtask

  task automatic t_immediate();
    issue(4'd2, 1'b0, 1'b1, 4'd0, 4'd0, 16'h7FFE, 32'h0);
    chk("R4 is_imm_o", 32'(is_imm_o), 1);
    chk("R4 immediate value", ea_o, 32'h0000_7FFE);
    idle();
  endtask

  task automatic t_illegal();
    issue(4'd2, 1'b1, 1'b1, 4'd6, 4'd0, 16'h0005, 32'h0);
    chk("R5 imm dest err", 32'(err_o), 1);
    chk("R5 imm dest no wb/flags", 32'({wb_en_o, is_imm_o, is_reg_o}), 0);
    chk("R5 imm dest ea zero", ea_o, 0);
    idle();
    issue(4'd12, 1'b0, 1'b1, 4'd6, 4'd0, 16'h0005, 32'h0);
    chk("R5 reserved code err", 32'(err_o), 1);
    chk("R5 reserved code no wb", 32'(wb_en_o), 0);
    idle();
    chk("R5 r6 unchanged", rf[6], 32'd1024);
  endtask

  task automatic t_indirect();
    issue(4'd3, 1'b0, 1'b1, 4'd8, 4'd0, 16'h0, 32'h0);
    chk("R6 register indirect", ea_o, 32'd1032);
    chk("R6 no wb", 32'(wb_en_o), 0);
    idle();
  endtask

  task automatic t_index();
    issue(4'd5, 1'b0, 1'b1, 4'd4, 4'd5, 16'd20, 32'h0);
    chk("R7 disp+Ri", ea_o, 32'd1036);
    idle();
    issue(4'd6, 1'b0, 1'b1, 4'd4, 4'd5, 16'd20, 32'h0);
    chk("R7 Ri+Rj", ea_o, 32'd2036);
    idle();
    issue(4'd7, 1'b0, 1'b1, 4'd4, 4'd5, 16'd8, 32'h0);
    chk("R7 disp+Ri+Rj", ea_o, 32'd2044);
    idle();
  endtask

  task automatic t_relative();
    issue(4'd8, 1'b0, 1'b1, 4'd0, 4'd0, 16'd12, 32'h0000_2000);
    chk("R8 pc relative fwd", ea_o, 32'h0000_200C);
    idle();
  endtask

  task automatic t_signext();
    issue(4'd5, 1'b0, 1'b1, 4'd3, 4'd0, 16'hFFF0, 32'h0);
    chk("R11 negative index disp", ea_o, 32'd996);
    idle();
    issue(4'd8, 1'b0, 1'b1, 4'd0, 4'd0, 16'hFFF0, 32'h0000_2000);
    chk("R11 negative pc disp", ea_o, 32'h0000_1FF0);
    idle();
    issue(4'd1, 1'b0, 1'b1, 4'd0, 4'd0, 16'h8000, 32'h0);
    chk("R11 absolute sign bit", ea_o, 32'hFFFF_8000);
    idle();
  endtask

  task automatic t_autoinc();
    issue(4'd9, 1'b0, 1'b1, 4'd1, 4'd0, 16'h0, 32'h0);
    chk("R9 word ea", ea_o, 32'd1004);
    chk("R9 word wb_en", 32'(wb_en_o), 1);
    chk("R9 word wb_idx", 32'(wb_idx_o), 1);
    chk("R9 word wb_data", wb_data_o, 32'd1008);
    idle();
    issue(4'd9, 1'b1, 1'b0, 4'd1, 4'd0, 16'h0, 32'h0);
    chk("R9 byte ea after update", ea_o, 32'd1008);
    chk("R9 byte wb_data", wb_data_o, 32'd1009);
    idle();
    chk("R9 r1 final", rf[1], 32'd1009);
  endtask

  task automatic t_autodec();
    issue(4'd10, 1'b0, 1'b1, 4'd2, 4'd0, 16'h0, 32'h0);
    chk("R10 word ea", ea_o, 32'd1004);
    chk("R10 word wb_data", wb_data_o, 32'd1004);
    chk("R10 wb_idx", 32'(wb_idx_o), 2);
    idle();
    issue(4'd10, 1'b0, 1'b0, 4'd2, 4'd0, 16'h0, 32'h0);
    chk("R10 byte ea", ea_o, 32'd1003);
    idle();
    chk("R10 r2 final", rf[2], 32'd1003);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_register();
    t_absolute();
    t_immediate();
    t_illegal();
    t_indirect();
    t_index();
    t_relative();
    t_signext();
    t_autoinc();
    t_autodec();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(100_000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule